// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block picks which of `NUM_LINES` interrupt lines should be served next and decides whether that line may interrupt the handler that is already running. Each line has a 4-bit urgency value, where a smaller number means more urgent. A 3-bit grouping setting divides that value at run time. The upper bits form a pre-emption field, which decides whether the line may interrupt a running handler. The lower bits form a sub-priority field, which only orders requests that are waiting.

The block keeps three bits per line: pending, enable and active. Pending and enable can each be set or cleared per line, and all three are readable. When the core accepts the current winner, that line's pending bit clears and its active bit sets. An end-of-handler strobe, which names a line, clears that line's active bit. The per-line urgency values, the grouping setting and the running handler's urgency are plain inputs, held in registers elsewhere.

Top module: `grouped_irq_arbiter`

## Requirements
- R1: Among lines that are both pending and enabled, the winner has the numerically smallest 4-bit urgency value. This is the same as ordering first by pre-emption field and then by sub-priority field.
- R2: When several eligible lines share the smallest urgency value, the line with the lowest index wins.
- R3: When no line is both pending and enabled, `win_valid` is 0 and `win_idx` is 0.
- R4: A grouping value k from 0 to 4 makes the upper k bits of the urgency value the pre-emption field and leaves the remaining 4-k lower bits as sub-priority. Grouping values 5, 6 and 7 behave like 4.
- R5: When `act_run` is 0 (no handler running), `take_req` equals `win_valid`.
- R6: When `act_run` is 1, `take_req` is 1 only if the winner's pre-emption field is strictly smaller than the pre-emption field of `act_prio`. Equal fields never give a take request.
- R7: With grouping value 0, `take_req` stays 0 whenever `act_run` is 1.
- R8: A 1 on bit i of `pend_set` or `pend_clr` sets or clears pending bit i at the next clock edge. If both are 1 for the same line, set wins.
- R9: A 1 on bit i of `en_set` or `en_clr` sets or clears enable bit i at the next clock edge, and set wins. A pending line that is not enabled never wins.
- R10: When `accept` and `take_req` are both 1 at a clock edge, the winner's pending bit clears and its active bit sets. `accept` while `take_req` is 0 changes nothing.
- R11: When `eoi` is 1 at a clock edge, the active bit of line `eoi_line` clears.
- R12: After reset, all pending, enable and active bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grp_sel | input | 3 | Grouping setting: number of pre-emption bits, saturating at 4 |
| prio_flat | input | NUM_LINES*4 | Urgency value per line; line i occupies bits [4i+3:4i] |
| pend_set | input | NUM_LINES | Per-line pending set strobes |
| pend_clr | input | NUM_LINES | Per-line pending clear strobes |
| en_set | input | NUM_LINES | Per-line enable set strobes |
| en_clr | input | NUM_LINES | Per-line enable clear strobes |
| act_run | input | 1 | A handler is currently running |
| act_prio | input | 4 | Urgency value of the running handler |
| accept | input | 1 | Core accepts the current winner |
| eoi | input | 1 | End-of-handler strobe |
| eoi_line | input | $clog2(NUM_LINES) | Line whose handler ends |
| pending_o | output | NUM_LINES | Pending bits |
| enable_o | output | NUM_LINES | Enable bits |
| active_o | output | NUM_LINES | Active bits |
| win_idx | output | $clog2(NUM_LINES) | Index of the winning line |
| win_valid | output | 1 | At least one line is pending and enabled |
| take_req | output | 1 | The winner may be taken now (idle core or pre-emption) |

## Verification
The assertions on acceptance and on end-of-handler assume that no input strobe touches the same line in the same cycle:
- `pend_set` does not name the line being accepted.
- `eoi_line` does not name that line either.

The bench meets this by pulsing `accept` and `eoi` only in cycles where every set and clear vector is zero. The assertions also assume that `act_prio` and the urgency values are stable between clock edges. The bench changes them only just after an edge and then waits before sampling.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W = 4;
  localparam int GRP_W  = 3;

  // Number of pre-emption bits selected by a grouping value; saturates.
  function automatic int unsigned preempt_bits(input logic [GRP_W-1:0] g);
    return (int'(g) > PRIO_W) ? PRIO_W : int'(g);
  endfunction

  // Upper bits of an urgency value that take part in pre-emption.
  function automatic logic [PRIO_W-1:0] preempt_field(input logic [PRIO_W-1:0] p,
                                                      input logic [GRP_W-1:0]  g);
    int unsigned k;
    k = preempt_bits(g);
    if (k == 0) return '0;
    return p >> (PRIO_W - k);
  endfunction
endpackage

// File: rtl/irq_line_state.sv
module irq_line_state #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pend_set,
  input  logic [NUM_LINES-1:0] pend_clr,
  input  logic [NUM_LINES-1:0] en_set,
  input  logic [NUM_LINES-1:0] en_clr,
  input  logic [NUM_LINES-1:0] take_hot,
  input  logic [NUM_LINES-1:0] end_hot,
  output logic [NUM_LINES-1:0] pending,
  output logic [NUM_LINES-1:0] enable,
  output logic [NUM_LINES-1:0] active
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending[i] <= 1'b0;
        enable[i]  <= 1'b0;
        active[i]  <= 1'b0;
      end else begin
        pending[i] <= (pending[i] & ~pend_clr[i] & ~take_hot[i]) | pend_set[i];
        enable[i]  <= (enable[i] & ~en_clr[i]) | en_set[i];
        active[i]  <= (active[i] & ~end_hot[i]) | take_hot[i];
      end
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]        req,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
  output logic                        found,
  output logic [IDX_W-1:0]            best_idx,
  output logic [PRIO_W-1:0]           best_prio
);
  // Ascending scan with strict compare: the lower index keeps a tie.
  always_comb begin
    found     = 1'b0;
    best_idx  = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (req[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] < best_prio)) begin
        found     = 1'b1;
        best_idx  = IDX_W'(i);
        best_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_preempt_gate.sv
module irq_preempt_gate
  import irq_arb_pkg::*;
(
  input  logic              cand_valid,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              act_run,
  input  logic [PRIO_W-1:0] act_prio,
  input  logic [GRP_W-1:0]  grp_sel,
  output logic              take_req
);
  logic [PRIO_W-1:0] cand_pre, act_pre;
  assign cand_pre = preempt_field(cand_prio, grp_sel);
  assign act_pre  = preempt_field(act_prio, grp_sel);
  assign take_req = cand_valid && (!act_run || (cand_pre < act_pre));
endmodule

// File: rtl/grouped_irq_arbiter.sv
module grouped_irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [GRP_W-1:0]            grp_sel,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
  input  logic [NUM_LINES-1:0]        pend_set,
  input  logic [NUM_LINES-1:0]        pend_clr,
  input  logic [NUM_LINES-1:0]        en_set,
  input  logic [NUM_LINES-1:0]        en_clr,
  input  logic                        act_run,
  input  logic [PRIO_W-1:0]           act_prio,
  input  logic                        accept,
  input  logic                        eoi,
  input  logic [IDX_W-1:0]            eoi_line,
  output logic [NUM_LINES-1:0]        pending_o,
  output logic [NUM_LINES-1:0]        enable_o,
  output logic [NUM_LINES-1:0]        active_o,
  output logic [IDX_W-1:0]            win_idx,
  output logic                        win_valid,
  output logic                        take_req
);
  logic [NUM_LINES-1:0] eligible;
  logic [NUM_LINES-1:0] take_hot;
  logic [NUM_LINES-1:0] end_hot;
  logic [PRIO_W-1:0]    win_prio;
  logic                 accept_fire;

  assign eligible    = pending_o & enable_o;
  assign accept_fire = accept && take_req;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_hot
    assign take_hot[i] = accept_fire && (win_idx == IDX_W'(i));
    assign end_hot[i]  = eoi && (eoi_line == IDX_W'(i));
  end

  irq_line_state #(.NUM_LINES(NUM_LINES)) u_state (
    .clk(clk), .rst_n(rst_n),
    .pend_set(pend_set), .pend_clr(pend_clr),
    .en_set(en_set), .en_clr(en_clr),
    .take_hot(take_hot), .end_hot(end_hot),
    .pending(pending_o), .enable(enable_o), .active(active_o)
  );

  irq_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .req(eligible), .prio_flat(prio_flat),
    .found(win_valid), .best_idx(win_idx), .best_prio(win_prio)
  );

  irq_preempt_gate u_gate (
    .cand_valid(win_valid), .cand_prio(win_prio),
    .act_run(act_run), .act_prio(act_prio), .grp_sel(grp_sel),
    .take_req(take_req)
  );
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [GRP_W-1:0]            grp_sel,
  input logic [NUM_LINES*PRIO_W-1:0] prio_flat,
  input logic [NUM_LINES-1:0]        pend_set,
  input logic                        act_run,
  input logic [PRIO_W-1:0]           act_prio,
  input logic                        accept,
  input logic                        eoi,
  input logic [IDX_W-1:0]            eoi_line,
  input logic [NUM_LINES-1:0]        pending_o,
  input logic [NUM_LINES-1:0]        enable_o,
  input logic [NUM_LINES-1:0]        active_o,
  input logic [IDX_W-1:0]            win_idx,
  input logic                        win_valid,
  input logic                        take_req
);
  logic [PRIO_W-1:0] chosen_prio;
  assign chosen_prio = prio_flat[win_idx*PRIO_W +: PRIO_W];

  assert_idle_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending_o & enable_o) == '0) |-> (!win_valid && win_idx == '0));

  assert_winner_eligible_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (pending_o[win_idx] && enable_o[win_idx]));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assert_winner_min_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_o[i] && enable_o[i]) |-> (win_valid && chosen_prio <= prio_flat[i*PRIO_W +: PRIO_W]));
    assert_tie_low_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_o[i] && enable_o[i] && IDX_W'(i) < win_idx) |-> (prio_flat[i*PRIO_W +: PRIO_W] > chosen_prio));
  end

  assert_idle_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !act_run |-> (take_req == win_valid));

  assert_strict_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && act_run) |-> (chosen_prio < act_prio));

  assert_grp0_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_run && grp_sel == '0) |-> !take_req);

  assert_accept_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && take_req && !pend_set[win_idx] && !(eoi && eoi_line == win_idx))
      |=> (active_o[$past(win_idx)] && !pending_o[$past(win_idx)]));

  assert_eoi_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !(accept && take_req && win_idx == eoi_line)) |=> !active_o[$past(eoi_line)]);
endmodule

bind grouped_irq_arbiter irq_arb_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_sel(grp_sel), .prio_flat(prio_flat),
  .pend_set(pend_set), .act_run(act_run), .act_prio(act_prio),
  .accept(accept), .eoi(eoi), .eoi_line(eoi_line),
  .pending_o(pending_o), .enable_o(enable_o), .active_o(active_o),
  .win_idx(win_idx), .win_valid(win_valid), .take_req(take_req)
);

// File: tb/grouped_irq_arbiter_bench.sv
module grouped_irq_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    grp_sel = '0;
  logic [N*4-1:0] prio_flat = '0;
  logic [N-1:0]  pend_set = '0, pend_clr = '0, en_set = '0, en_clr = '0;
  logic          act_run = 1'b0;
  logic [3:0]    act_prio = '0;
  logic          accept = 1'b0, eoi = 1'b0;
  logic [IW-1:0] eoi_line = '0;
  logic [N-1:0]  pending_o, enable_o, active_o;
  logic [IW-1:0] win_idx;
  logic          win_valid, take_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grouped_irq_arbiter #(.NUM_LINES(N)) u_grouped_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .grp_sel(grp_sel), .prio_flat(prio_flat),
    .pend_set(pend_set), .pend_clr(pend_clr), .en_set(en_set), .en_clr(en_clr),
    .act_run(act_run), .act_prio(act_prio), .accept(accept), .eoi(eoi),
    .eoi_line(eoi_line), .pending_o(pending_o), .enable_o(enable_o),
    .active_o(active_o), .win_idx(win_idx), .win_valid(win_valid), .take_req(take_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock edge, then settle away from it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_strobes();
    pend_set = '0; pend_clr = '0; en_set = '0; en_clr = '0;
    accept = 1'b0; eoi = 1'b0;
  endtask

  // Pre-emption field per the grouping rule, computed by division.
  function automatic int pre_of(input int p, input int g);
    int k;
    k = (g > 4) ? 4 : g;
    return p / (1 << (4 - k));
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    chk("R12 pending", int'(pending_o), 0);
    chk("R12 enable", int'(enable_o), 0);
    chk("R12 active", int'(active_o), 0);
    chk("R12 valid", int'(win_valid), 0);
    rst_n = 1'b1;
    tick();

    // R9: enable set/clear, set wins
    en_set = 8'hFF; tick(); clear_strobes();
    chk("R9 enable all", int'(enable_o), 255);
    en_clr = 8'h0C; tick(); clear_strobes();
    chk("R9 enable clr", int'(enable_o), 8'hF3);
    en_set = 8'h04; en_clr = 8'h04; tick(); clear_strobes();
    chk("R9 enable set wins", int'(enable_o), 8'hF7);
    en_set = 8'hFF; tick(); clear_strobes();

    // R8: pending set/clear, set wins
    pend_set = 8'h05; tick(); clear_strobes();
    chk("R8 pend set", int'(pending_o), 5);
    pend_clr = 8'h01; tick(); clear_strobes();
    chk("R8 pend clr", int'(pending_o), 4);
    pend_set = 8'h04; pend_clr = 8'h04; tick(); clear_strobes();
    chk("R8 pend set wins", int'(pending_o), 4);
    pend_clr = 8'hFF; tick(); clear_strobes();
    chk("R3 none pending valid", int'(win_valid), 0);
    chk("R3 none pending idx", int'(win_idx), 0);

    // R1 R2 R3 R5 R9: arbitration sweep, no running handler
    act_run = 1'b0;
    for (int it = 0; it < 300; it++) begin
      logic [N-1:0] pm, em;
      int best, bidx;
      pm = N'($urandom_range(0, 255));
      em = (it % 3 == 0) ? N'($urandom_range(0, 255)) : '1;
      if (it % 17 == 0) pm = '0;
      for (int i = 0; i < N; i++)
        prio_flat[i*4 +: 4] = (it % 2 == 0) ? 4'($urandom_range(0, 3)) : 4'($urandom_range(0, 15));
      pend_clr = '1; pend_set = pm; en_clr = '1; en_set = em;
      tick(); clear_strobes();
      best = 16; bidx = 0;
      for (int i = 0; i < N; i++)
        if (pm[i] && em[i] && int'(prio_flat[i*4 +: 4]) < best) begin
          best = int'(prio_flat[i*4 +: 4]); bidx = i;
        end
      chk("R3 R9 valid", int'(win_valid), (best < 16) ? 1 : 0);
      chk("R1 R2 index", int'(win_idx), bidx);
      chk("R5 idle take", int'(take_req), (best < 16) ? 1 : 0);
    end

    // R4 R6 R7: exhaustive pre-emption sweep on one eligible line
    en_set = '1; pend_clr = '1; pend_set = 8'h08; tick(); clear_strobes();
    act_run = 1'b1;
    for (int g = 0; g < 8; g++)
      for (int p = 0; p < 16; p++)
        for (int a = 0; a < 16; a++) begin
          grp_sel = 3'(g); prio_flat[3*4 +: 4] = 4'(p); act_prio = 4'(a);
          #1;
          if (g == 0) chk("R7 no preempt", int'(take_req), 0);
          else chk("R4 R6 preempt", int'(take_req), (pre_of(p, g) < pre_of(a, g)) ? 1 : 0);
        end

    // R10: accept blocked when take_req low changes nothing
    grp_sel = 3'd4; act_prio = 4'd2; prio_flat[3*4 +: 4] = 4'd5; #1;
    accept = 1'b1; tick(); clear_strobes();
    chk("R10 blocked pending", int'(pending_o), 8'h08);
    chk("R10 blocked active", int'(active_o), 0);

    // R10: accepted line moves from pending to active
    act_run = 1'b0; #1;
    accept = 1'b1; tick(); clear_strobes();
    chk("R10 pending cleared", int'(pending_o), 0);
    chk("R10 active set", int'(active_o), 8'h08);

    // R11: end of handler on another line leaves line 3, then clears it
    eoi = 1'b1; eoi_line = 3'd1; tick(); clear_strobes();
    chk("R11 other line", int'(active_o), 8'h08);
    eoi = 1'b1; eoi_line = 3'd3; tick(); clear_strobes();
    chk("R11 eoi clears", int'(active_o), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule